// File: doc/BRIEF.md
# Reset Boot Fetch Adapter

This block stands between the processor's instruction fetch port and the static memory bus. It serves the fetches that run right after reset. While reset is held it samples a three-bit strap. That value fixes the boot device and the width of the data path until the next reset. Each fetch address is a virtual address in the uncached segment. The block turns it into a physical, word-aligned address by clearing its three most significant bits. The reset vector 0xBFC00000 therefore reaches the bus as 0x1FC00000.

With a 32-bit boot memory, each fetch becomes one full-width read on chip select 0. With a 16-bit boot memory, each fetch becomes two halfword reads, first at the word address and then at the word address plus two. The two halfwords are then joined into one word. A byte-order bit decides which halfword goes into the low half of the word. This bit is little-endian after every reset, whatever byte order the processor starts in. Software can overwrite it through a write strobe. Strap codes that ask for a device this block does not serve raise an error flag. In that case the block accepts no fetch and starts no bus cycle.

Top module: `boot_fetch_adapter`

## Requirements
- R1: A fetch of virtual address 0xBFC00000 produces a first bus read at physical address 0x1FC00000.
- R2: For any fetch address, the bus address has bits 31:29 cleared and bits 1:0 cleared on the first read. Bits 28:2 are copied from the fetch address.
- R3: With strap code 0 (32-bit memory), a fetch makes exactly one bus read with `bus_wide` = 1. The response word equals `bus_rdata` of that read.
- R4: With strap code 1 (16-bit memory), a fetch makes exactly two bus reads with `bus_wide` = 0, at the word address and then at the word address + 2. Only `bus_rdata[15:0]` is used.
- R5: In little-endian order (`endian_big` state 0), the halfword read from the lower address lands in response bits 15:0 and the second halfword lands in bits 31:16.
- R6: After a write with `endian_wr` = 1 and `endian_big` = 1, the order is big-endian: the lower-address halfword lands in bits 31:16 and the second halfword in bits 15:0.
- R7: Strap codes 2, 3, 4, 5, 6 and 7 drive `boot_err` = 1 and hold `fetch_ready` = 0. No `bus_req` is raised while fetches are offered.
- R8: The strap value is the one present on the last clock edge with reset asserted. Changes to `boot_strap` after reset has been released do not change the mode or `boot_err`.
- R9: `resp_valid` rises only after every bus read of the word has been acknowledged. It stays high with `resp_data` stable until `resp_ready` is seen.
- R10: `bus_req` stays high with `bus_addr` stable until `bus_ack` is seen, whatever the number of wait states.
- R11: Reset returns the byte order to little-endian, even after software has chosen big-endian.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; the strap is sampled while it is low |
| boot_strap | input | 3 | Boot device strap code |
| endian_wr | input | 1 | Write strobe for the byte-order bit |
| endian_big | input | 1 | Value written to the byte-order bit (1 = big-endian) |
| fetch_valid | input | 1 | Fetch request valid |
| fetch_ready | output | 1 | Adapter can accept a fetch |
| fetch_addr | input | 32 | Virtual fetch address |
| resp_valid | output | 1 | Fetched word valid |
| resp_ready | input | 1 | Fetch port accepts the word |
| resp_data | output | 32 | Fetched instruction word |
| bus_req | output | 1 | Read request on chip select 0 |
| bus_addr | output | 32 | Physical byte address of the read |
| bus_wide | output | 1 | 1 = 32-bit read, 0 = 16-bit read |
| bus_ack | input | 1 | Read data present on `bus_rdata` |
| bus_rdata | input | 32 | Read data, halfword reads on bits 15:0 |
| boot_err | output | 1 | Strap selects a device this block does not serve |

## Verification
The hardest case to reach from the ports is the pair of halfword reads whose results must be joined in the right order. Wait states vary for each read and the response sits behind a stalled `resp_ready` at the same time. The bus model inserts a chosen number of wait states before each acknowledge. It answers every halfword read with data derived from its own address and puts garbage on the upper lines, so a wrong address, a wrong order or a wrong lane shows up directly in the word. The stimulus also holds `resp_ready` low for several cycles on selected fetches. It writes the byte-order bit between fetches and then resets to show that the order returns to little-endian. It changes the strap after reset release to show that the latched value governs.

// File: rtl/bfa_pkg.sv
package bfa_pkg;

   typedef enum logic [1:0] {
      BM_ROM32 = 2'd0,
      BM_ROM16 = 2'd1,
      BM_NONE  = 2'd2
   } boot_mode_t;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_BEAT0 = 2'd1,
      ST_BEAT1 = 2'd2,
      ST_RESP  = 2'd3
   } seq_state_t;

endpackage

// File: rtl/bfa_strap_latch.sv
module bfa_strap_latch
   import bfa_pkg::*;
#(
   parameter int STRAP_W    = 3,
   parameter int ROM32_CODE = 0,
   parameter int ROM16_CODE = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [STRAP_W-1:0] strap_in,
   output boot_mode_t         mode,
   output logic               unsupported
);

   logic [STRAP_W-1:0] strap_q;

   // sampled on every edge while reset is held, frozen afterwards
   always_ff @(posedge clk) begin
      if (!rst_n) strap_q <= strap_in;
   end

   always_comb begin
      if (strap_q == STRAP_W'(ROM32_CODE))      mode = BM_ROM32;
      else if (strap_q == STRAP_W'(ROM16_CODE)) mode = BM_ROM16;
      else                                      mode = BM_NONE;
   end

   assign unsupported = (mode == BM_NONE);

endmodule

// File: rtl/bfa_half_pack.sv
module bfa_half_pack #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W/2-1:0] first_half,
   input  logic [DATA_W/2-1:0] second_half,
   input  logic                big_end,
   output logic [DATA_W-1:0]   word
);

   localparam int HALF_W = DATA_W / 2;

   // lane h takes the first-read halfword when its position matches the order
   for (genvar h = 0; h < 2; h++) begin : g_lane
      assign word[h*HALF_W +: HALF_W] = ((h == 1) == big_end) ? first_half : second_half;
   end

endmodule

// File: rtl/bfa_beat_seq.sv
module bfa_beat_seq
   import bfa_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int SEG_BITS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  boot_mode_t        mode,
   input  logic              big_end,
   input  logic              fetch_valid,
   output logic              fetch_ready,
   input  logic [ADDR_W-1:0] fetch_addr,
   output logic              resp_valid,
   input  logic              resp_ready,
   output logic [DATA_W-1:0] resp_data,
   output logic              bus_req,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_wide,
   input  logic              bus_ack,
   input  logic [DATA_W-1:0] bus_rdata
);

   localparam int HALF_W   = DATA_W / 2;
   localparam int ALIGN    = $clog2(DATA_W / 8);
   localparam int HALF_OFS = DATA_W / 16;

   seq_state_t        state_q;
   logic [ADDR_W-1:0] base_q;
   logic [HALF_W-1:0] first_q;
   logic [DATA_W-1:0] word_q;
   logic [DATA_W-1:0] joined;
   logic [ADDR_W-1:0] phys_word;
   logic              unused_bits;

   assign phys_word = {{SEG_BITS{1'b0}}, fetch_addr[ADDR_W-SEG_BITS-1:ALIGN], {ALIGN{1'b0}}};
   assign unused_bits = ^{fetch_addr[ADDR_W-1 -: SEG_BITS], fetch_addr[ALIGN-1:0]};

   bfa_half_pack #(.DATA_W(DATA_W)) pack_i (
      .first_half  (first_q),
      .second_half (bus_rdata[HALF_W-1:0]),
      .big_end     (big_end),
      .word        (joined)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         base_q  <= '0;
         first_q <= '0;
         word_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (fetch_valid && fetch_ready) begin
                  base_q  <= phys_word;
                  state_q <= ST_BEAT0;
               end
            end
            ST_BEAT0: begin
               if (bus_ack) begin
                  if (mode == BM_ROM32) begin
                     word_q  <= bus_rdata;
                     state_q <= ST_RESP;
                  end else begin
                     first_q <= bus_rdata[HALF_W-1:0];
                     state_q <= ST_BEAT1;
                  end
               end
            end
            ST_BEAT1: begin
               if (bus_ack) begin
                  word_q  <= joined;
                  state_q <= ST_RESP;
               end
            end
            default: begin
               if (resp_ready) state_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign fetch_ready = (state_q == ST_IDLE) && (mode != BM_NONE);
   assign bus_req     = (state_q == ST_BEAT0) || (state_q == ST_BEAT1);
   assign bus_addr    = (state_q == ST_BEAT1) ? base_q + ADDR_W'(HALF_OFS) : base_q;
   assign bus_wide    = (mode == BM_ROM32);
   assign resp_valid  = (state_q == ST_RESP);
   assign resp_data   = word_q;

endmodule

// File: rtl/boot_fetch_adapter.sv
module boot_fetch_adapter
   import bfa_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int SEG_BITS   = 3,
   parameter int STRAP_W    = 3,
   parameter int ROM32_CODE = 0,
   parameter int ROM16_CODE = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [STRAP_W-1:0] boot_strap,
   input  logic               endian_wr,
   input  logic               endian_big,
   input  logic               fetch_valid,
   output logic               fetch_ready,
   input  logic [ADDR_W-1:0]  fetch_addr,
   output logic               resp_valid,
   input  logic               resp_ready,
   output logic [DATA_W-1:0]  resp_data,
   output logic               bus_req,
   output logic [ADDR_W-1:0]  bus_addr,
   output logic               bus_wide,
   input  logic               bus_ack,
   input  logic [DATA_W-1:0]  bus_rdata,
   output logic               boot_err
);

   if (DATA_W % 16 != 0 || DATA_W < 16) begin : g_bad_data_w
      $error("DATA_W must be a multiple of 16");
   end
   if (ADDR_W <= SEG_BITS + $clog2(DATA_W / 8)) begin : g_bad_addr_w
      $error("ADDR_W too small for segment and alignment bits");
   end
   if (ROM32_CODE == ROM16_CODE || ROM32_CODE >= (1 << STRAP_W) || ROM16_CODE >= (1 << STRAP_W)) begin : g_bad_codes
      $error("strap codes must differ and fit in STRAP_W");
   end

   boot_mode_t mode;
   logic       big_q;

   // byte order: little-endian after every reset, software may overwrite
   always_ff @(posedge clk) begin
      if (!rst_n)         big_q <= 1'b0;
      else if (endian_wr) big_q <= endian_big;
   end

   bfa_strap_latch #(
      .STRAP_W    (STRAP_W),
      .ROM32_CODE (ROM32_CODE),
      .ROM16_CODE (ROM16_CODE)
   ) strap_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .strap_in    (boot_strap),
      .mode        (mode),
      .unsupported (boot_err)
   );

   bfa_beat_seq #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .SEG_BITS (SEG_BITS)
   ) seq_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode        (mode),
      .big_end     (big_q),
      .fetch_valid (fetch_valid),
      .fetch_ready (fetch_ready),
      .fetch_addr  (fetch_addr),
      .resp_valid  (resp_valid),
      .resp_ready  (resp_ready),
      .resp_data   (resp_data),
      .bus_req     (bus_req),
      .bus_addr    (bus_addr),
      .bus_wide    (bus_wide),
      .bus_ack     (bus_ack),
      .bus_rdata   (bus_rdata)
   );

endmodule

// File: rtl/bfa_chk.sv
module bfa_chk #(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int SEG_BITS = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fetch_ready,
   input logic              resp_valid,
   input logic              resp_ready,
   input logic [DATA_W-1:0] resp_data,
   input logic              bus_req,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_ack,
   input logic              boot_err
);

   // R7
   no_bus_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      boot_err |-> (!bus_req && !fetch_ready));

   // R8
   err_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> $stable(boot_err));

   // R2
   phys_segment_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> (bus_addr[ADDR_W-1 -: SEG_BITS] == '0));

   // R10
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr)));

   // R9
   resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_data)));

   // R9
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> !bus_req);

endmodule

bind boot_fetch_adapter bfa_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .SEG_BITS (SEG_BITS)
) chk_i (.*);

// File: tb/boot_fetch_adapter_tb_top.sv
module boot_fetch_adapter_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  boot_strap = 3'd0;
   logic        endian_wr = 1'b0;
   logic        endian_big = 1'b0;
   logic        fetch_valid = 1'b0;
   logic        fetch_ready;
   logic [31:0] fetch_addr = '0;
   logic        resp_valid;
   logic        resp_ready = 1'b1;
   logic [31:0] resp_data;
   logic        bus_req;
   logic [31:0] bus_addr;
   logic        bus_wide;
   logic        bus_ack = 1'b0;
   logic [31:0] bus_rdata = '0;
   logic        boot_err;

   always #10 clk = ~clk;

   boot_fetch_adapter dut_i (
      .clk(clk), .rst_n(rst_n), .boot_strap(boot_strap),
      .endian_wr(endian_wr), .endian_big(endian_big),
      .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_addr(fetch_addr),
      .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_data(resp_data),
      .bus_req(bus_req), .bus_addr(bus_addr), .bus_wide(bus_wide),
      .bus_ack(bus_ack), .bus_rdata(bus_rdata), .boot_err(boot_err)
   );

   typedef struct {
      logic [31:0] data;
      int          beats;
   } exp_t;

   exp_t        exp_q[$];
   logic [31:0] beat_addr[$];
   logic        beat_wide[$];
   int          n_vec = 0;
   int          n_bad = 0;
   int          wait_states = 0;
   int          wcnt = 0;
   int          req_cycles = 0;
   int          stall_cnt = 0;

   function automatic logic [15:0] half_of(logic [31:0] a);
      return a[15:0] ^ 16'h1234;
   endfunction

   function automatic logic [31:0] word_of(logic [31:0] a);
      return {~a[15:0], a[15:0] ^ 16'h1234};
   endfunction

   function automatic logic [31:0] phys_of(logic [31:0] a);
      return {3'b000, a[28:2], 2'b00};
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // bus model: acknowledges after wait_states cycles, logs every read
   always @(negedge clk) begin
      if (bus_req) req_cycles++;
      if (bus_ack) begin
         bus_ack = 1'b0;
         wcnt = 0;
      end else if (bus_req) begin
         if (wcnt >= wait_states) begin
            bus_ack = 1'b1;
            bus_rdata = bus_wide ? word_of(bus_addr) : {16'hDEAD, half_of(bus_addr)};
            beat_addr.push_back(bus_addr);
            beat_wide.push_back(bus_wide);
         end else begin
            wcnt++;
         end
      end
   end

   // monitor: drives resp_ready, pops and compares on each handshake
   always @(negedge clk) begin
      if (stall_cnt > 0) begin
         resp_ready = 1'b0;
         stall_cnt--;
      end else begin
         resp_ready = 1'b1;
      end
      if (rst_n && resp_valid && resp_ready) begin
         if (exp_q.size() == 0) begin
            chk("R9 unexpected response", resp_data, 32'hx);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk("R9 beats done before response", 32'(beat_addr.size()), 32'(e.beats));
            chk("R5/R6/R3 response word", resp_data, e.data);
         end
      end
   end

   task automatic do_reset(logic [2:0] strap);
      @(negedge clk);
      rst_n = 1'b0;
      boot_strap = strap;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic do_fetch(string req, logic [31:0] a, bit half, bit big, int stall);
      logic [31:0] p;
      exp_t e;
      p = phys_of(a);
      if (!half) begin
         e.data = word_of(p);
         e.beats = 1;
      end else begin
         e.data = big ? {half_of(p), half_of(p + 32'd2)} : {half_of(p + 32'd2), half_of(p)};
         e.beats = 2;
      end
      beat_addr.delete();
      beat_wide.delete();
      exp_q.push_back(e);
      @(negedge clk);
      fetch_valid = 1'b1;
      fetch_addr = a;
      while (!fetch_ready) @(negedge clk);
      stall_cnt = stall;
      @(negedge clk);
      fetch_valid = 1'b0;
      while (exp_q.size() != 0) @(negedge clk);
      chk({req, " beat count"}, 32'(beat_addr.size()), 32'(e.beats));
      if (beat_addr.size() >= 1) begin
         chk({req, " first address"}, beat_addr[0], p);
         chk({req, " first width"}, 32'(beat_wide[0]), 32'(!half));
      end
      if (half && beat_addr.size() >= 2) begin
         chk({req, " second address"}, beat_addr[1], p + 32'd2);
         chk({req, " second width"}, 32'(beat_wide[1]), 32'd0);
      end
   endtask

   task automatic write_order(logic big);
      @(negedge clk);
      endian_wr = 1'b1;
      endian_big = big;
      @(negedge clk);
      endian_wr = 1'b0;
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL R9 watchdog act=hung exp=done");
      summary();
      $finish;
   end

   initial begin
      // reset state, 32-bit mode
      do_reset(3'd0);
      chk("R3 reset resp_valid", 32'(resp_valid), 32'd0);
      chk("R3 reset bus_req", 32'(bus_req), 32'd0);
      chk("R7 reset boot_err strap0", 32'(boot_err), 32'd0);
      chk("R3 reset fetch_ready", 32'(fetch_ready), 32'd1);

      // R1 R3: reset vector, no wait states
      wait_states = 0;
      do_fetch("R1", 32'hBFC0_0000, 1'b0, 1'b0, 0);
      // R3 with wait states and a stalled response
      wait_states = 2;
      do_fetch("R3", 32'hBFC0_0104, 1'b0, 1'b0, 4);
      // R2: unaligned, all segment bits set
      wait_states = 1;
      do_fetch("R2", 32'hFFFF_FFFE, 1'b0, 1'b0, 0);

      // 16-bit mode; strap changed after release must be ignored (R8)
      do_reset(3'd1);
      boot_strap = 3'd0;
      @(negedge clk);
      chk("R8 boot_err after strap change", 32'(boot_err), 32'd0);
      wait_states = 0;
      do_fetch("R4 R5 R8", 32'hBFC0_0000, 1'b1, 1'b0, 0);
      // R10: long wait states on both halves, stalled response (R9)
      wait_states = 3;
      do_fetch("R10", 32'hBFC0_0010, 1'b1, 1'b0, 5);
      // R6: big-endian after a write
      write_order(1'b1);
      wait_states = 1;
      do_fetch("R6", 32'hBFC0_0020, 1'b1, 1'b1, 2);
      do_fetch("R6 second", 32'hA000_0F00, 1'b1, 1'b1, 0);

      // R11: reset returns order to little-endian
      do_reset(3'd1);
      do_fetch("R11", 32'hBFC0_0040, 1'b1, 1'b0, 0);
      // software back to little-endian explicitly (R5)
      write_order(1'b1);
      write_order(1'b0);
      do_fetch("R5 rewrite", 32'hBFC0_0044, 1'b1, 1'b0, 0);

      // R7: each code this block does not serve
      for (int s = 2; s < 8; s++) begin
         do_reset(3'(s));
         chk("R7 boot_err", 32'(boot_err), 32'd1);
         chk("R7 fetch_ready", 32'(fetch_ready), 32'd0);
         req_cycles = 0;
         fetch_addr = 32'hBFC0_0000;
         fetch_valid = 1'b1;
         repeat (8) @(negedge clk);
         fetch_valid = 1'b0;
         chk("R7 bus cycles", 32'(req_cycles), 32'd0);
         chk("R7 resp_valid", 32'(resp_valid), 32'd0);
      end

      // back to a served code to close out R8 with a flipped strap
      do_reset(3'd0);
      boot_strap = 3'd7;
      repeat (2) @(negedge clk);
      chk("R8 err stays low", 32'(boot_err), 32'd0);
      do_fetch("R8 32-bit kept", 32'hBFC0_0080, 1'b0, 1'b0, 0);

      summary();
      $finish;
   end

endmodule